// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Controller

This block gives software control over a bank of general-purpose pins through a small word-addressed register bus. Each pin has its own direction bit and output latch. Software can read back every pin's level. Each pin can also raise an interrupt on a rising edge, a falling edge, either edge, a high level or a low level. The controller latches each detection in a per-pin status bit. Software clears these bits by writing ones. A per-pin mask decides which latched bits reach the single combined interrupt line.

The register bus has no back-pressure. A write takes effect at the clock edge where `bus_we` is high. A read returns data in the same cycle, because `bus_rdata` is a combinational function of `bus_addr`. Pin inputs pass through a two-flop synchroniser, and a delayed copy of the synchronised value feeds edge detection. A software reset register can hold every configuration and status register at its default value.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers are 32-bit words selected by `bus_addr[5:2]`:
  - 0x00 enable
  - 0x04 status
  - 0x08 pending (status AND NOT mask)
  - 0x0C clear
  - 0x10 mask set (reads back the mask)
  - 0x14 mask clear
  - 0x18 output data
  - 0x1C input data
  - 0x20 direction
  - 0x24 mode A
  - 0x28 mode B
  - 0x38 use-select
  - 0x3C software reset

  The clear address, the mask-clear address and the reserved words 0x2C to 0x34 read as zero.
- R2: `pin_oe` equals the direction register (1 = output) and `pin_out` equals the output data register. Both are zero after reset.
- R3: The input data register returns `pin_in` as it was two clock edges earlier.
- R4: Each pin has a 3-bit mode code: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 either edge. Codes 5 to 7 never set status. Pin i below 8 uses bits [4i+2:4i] of mode A, and pin i of 8 or more uses bits [4(i-8)+2:4(i-8)] of mode B. The fourth bit of each nibble, and nibbles with no pin, read as zero.
- R5: A pin transition seen at `pin_in` sets that pin's status on the third clock edge after the change, and not on the second.
- R6: In level modes the status bit is set again on every cycle while the level holds. A clear therefore only takes effect once the level is gone.
- R7: A detection latches status only while the pin's enable bit is 1. Status bits that are already set stay set when the enable bit is cleared.
- R8: Writing 1 to a bit of the clear register clears that status bit, and writing 0 has no effect. When a clear and a detection fall in the same cycle, the detection wins.
- R9: Writing a 1 to mask set masks that pin, and writing a 1 to mask clear unmasks it. `irq` is high exactly when some status bit is set and unmasked.
- R10: While bit 0 of the reset register is 1, the enable, status, mask, output, direction, mode and use-select registers are held at zero, and writes to them are ignored. Writing 0 to that bit releases the hold. The bit reads back.
- R11: The use-select register is a plain 12-bit read/write register that resets to zero and has no effect on the pins.
- R12: Bits 12 to 31 of the per-pin registers are ignored on write and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pin_in | input | 12 | Pin levels, asynchronous to clk |
| pin_out | output | 12 | Output data to the pins |
| pin_oe | output | 12 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `bus_we` is a single-cycle strobe with a stable, word-aligned `bus_addr`. They also assume that `pin_in` is clean once it has passed the synchroniser. The bench drives the bus and the pins only on falling clock edges, issues one access at a time, and holds the pin levels for several cycles between changes. As a result, every detection can be attributed to exactly one transition.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // word indices of the register map (bus_addr[5:2])
  localparam logic [3:0] IDX_ENABLE = 4'h0;
  localparam logic [3:0] IDX_STATUS = 4'h1;
  localparam logic [3:0] IDX_PEND   = 4'h2;
  localparam logic [3:0] IDX_CLEAR  = 4'h3;
  localparam logic [3:0] IDX_MSET   = 4'h4;
  localparam logic [3:0] IDX_MCLR   = 4'h5;
  localparam logic [3:0] IDX_OUT    = 4'h6;
  localparam logic [3:0] IDX_IN     = 4'h7;
  localparam logic [3:0] IDX_DIR    = 4'h8;
  localparam logic [3:0] IDX_MODEA  = 4'h9;
  localparam logic [3:0] IDX_MODEB  = 4'hA;
  localparam logic [3:0] IDX_USESEL = 4'hE;
  localparam logic [3:0] IDX_SRST   = 4'hF;

  localparam int PINS_PER_MODE_REG = 8;

  typedef enum logic [2:0] {
    DET_FALL = 3'd0,
    DET_RISE = 3'd1,
    DET_LOW  = 3'd2,
    DET_HIGH = 3'd3,
    DET_BOTH = 3'd4
  } det_mode_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= d_in;
      cur    <= meta_q;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/gpio_pin_det.sv
module gpio_pin_det
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       cur,
  input  logic       prev,
  input  logic       en,
  input  logic       clr,
  input  logic       mode_we,
  input  logic [2:0] mode_wd,
  output logic [2:0] mode_q,
  output logic       status
);
  logic hit;

  always_comb begin
    unique case (mode_q)
      DET_FALL: hit = prev & ~cur;
      DET_RISE: hit = ~prev & cur;
      DET_LOW:  hit = ~cur;
      DET_HIGH: hit = cur;
      DET_BOTH: hit = prev ^ cur;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      status <= 1'b0;
    end else if (srst) begin
      mode_q <= '0;
      status <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wd;
      if (en && hit)  status <= 1'b1;
      else if (clr)   status <= 1'b0;
    end
  end

  // R8: a detection in the same cycle as a clear wins
  a_r8_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit && !srst) |=> status);
  // R8: a clear with no detection empties the bit
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(en && hit) && !srst) |=> !status);
  // R7: nothing latches while the pin is disabled
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !status) |=> !status);
  // R4: codes 5..7 never set status
  a_r4_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q > 3'd4 && !mode_we && !status) |=> !status);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 12,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int PAD = 32 - NPINS;
  localparam int NIB = PINS_PER_MODE_REG;

  logic [3:0]       idx;
  logic [NPINS-1:0] ien_q, mask_q, out_q, dir_q, use_q, status, cur, prev;
  logic             srst_q;
  logic [2:0]       mode_q [NPINS];
  logic [3:0]       nib_a [NIB];
  logic [3:0]       nib_b [NIB];
  logic [31:0]      mode_a_rd, mode_b_rd;
  logic             unused_bus;

  assign idx        = bus_addr[5:2];
  assign unused_bus = ^{bus_addr[1:0], bus_wdata};

  function automatic logic [31:0] zx(input logic [NPINS-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .cur(cur), .prev(prev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          srst_q <= 1'b0;
    else if (bus_we && idx == IDX_SRST)  srst_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0; mask_q <= '0; out_q <= '0; dir_q <= '0; use_q <= '0;
    end else if (srst_q) begin
      ien_q <= '0; mask_q <= '0; out_q <= '0; dir_q <= '0; use_q <= '0;
    end else if (bus_we) begin
      unique case (idx)
        IDX_ENABLE: ien_q  <= bus_wdata[NPINS-1:0];
        IDX_MSET:   mask_q <= mask_q | bus_wdata[NPINS-1:0];
        IDX_MCLR:   mask_q <= mask_q & ~bus_wdata[NPINS-1:0];
        IDX_OUT:    out_q  <= bus_wdata[NPINS-1:0];
        IDX_DIR:    dir_q  <= bus_wdata[NPINS-1:0];
        IDX_USESEL: use_q  <= bus_wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam logic [3:0] MIDX = (i < NIB) ? IDX_MODEA : IDX_MODEB;
    localparam int         POS  = 4 * (i % NIB);
    gpio_pin_det u_det (
      .clk(clk), .rst_n(rst_n), .srst(srst_q),
      .cur(cur[i]), .prev(prev[i]), .en(ien_q[i]),
      .clr(bus_we && idx == IDX_CLEAR && bus_wdata[i]),
      .mode_we(bus_we && idx == MIDX),
      .mode_wd(bus_wdata[POS +: 3]),
      .mode_q(mode_q[i]), .status(status[i])
    );
  end

  for (genvar j = 0; j < NIB; j++) begin : g_nib
    if (j < NPINS) begin : g_a
      assign nib_a[j] = {1'b0, mode_q[j]};
    end else begin : g_a0
      assign nib_a[j] = '0;
    end
    if (j + NIB < NPINS) begin : g_b
      assign nib_b[j] = {1'b0, mode_q[j+NIB]};
    end else begin : g_b0
      assign nib_b[j] = '0;
    end
  end

  always_comb begin
    for (int j = 0; j < NIB; j++) begin
      mode_a_rd[4*j +: 4] = nib_a[j];
      mode_b_rd[4*j +: 4] = nib_b[j];
    end
  end

  always_comb begin
    unique case (idx)
      IDX_ENABLE: bus_rdata = zx(ien_q);
      IDX_STATUS: bus_rdata = zx(status);
      IDX_PEND:   bus_rdata = zx(status & ~mask_q);
      IDX_MSET:   bus_rdata = zx(mask_q);
      IDX_OUT:    bus_rdata = zx(out_q);
      IDX_IN:     bus_rdata = zx(cur);
      IDX_DIR:    bus_rdata = zx(dir_q);
      IDX_MODEA:  bus_rdata = mode_a_rd;
      IDX_MODEB:  bus_rdata = mode_b_rd;
      IDX_USESEL: bus_rdata = zx(use_q);
      IDX_SRST:   bus_rdata = {31'b0, srst_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(status & ~mask_q);

  // R10: a held soft reset brings every register to its default
  a_r10_srst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (ien_q == '0 && mask_q == '0 && status == '0 &&
                pin_oe == '0 && pin_out == '0 && use_q == '0));
  // R9: a mask-set write masks every pin it names
  a_r9_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && idx == IDX_MSET && !srst_q) |=>
      ((mask_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));
  // R9: with every pin masked the request line stays low
  a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == {NPINS{1'b1}}) |-> !irq);
  // R2: output enables only change after a direction write or soft reset
  a_r2_oe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_we && idx == IDX_DIR) && !srst_q) |=> $stable(pin_oe));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int NP = 12;
  localparam logic [5:0] A_EN = 6'h00, A_ST = 6'h04, A_PD = 6'h08, A_CL = 6'h0C,
    A_MS = 6'h10, A_MC = 6'h14, A_OUT = 6'h18, A_IN = 6'h1C, A_DIR = 6'h20,
    A_MA = 6'h24, A_MB = 6'h28, A_RSV = 6'h2C, A_US = 6'h38, A_SR = 6'h3C;
  localparam int K_RD = 0, K_IRQ = 1, K_OE = 2, K_OUT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [5:0] a,
                     input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops each expected item and compares it with the design
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_IRQ:   act = {31'b0, irq};
          K_OE:    act = {20'b0, pin_oe};
          K_OUT:   act = {20'b0, pin_out};
          default: act = bus_rdata;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R2 reset state
    chk(K_OE,  A_EN, 32'h0, "R2 oe reset");
    chk(K_OUT, A_EN, 32'h0, "R2 out reset");
    chk(K_RD,  A_EN, 32'h0, "R1 enable reset");
    // R2 / R12 direction and output
    wr(A_DIR, 32'hFFFF_F0F0);
    wr(A_OUT, 32'h0000_0FA5);
    chk(K_OE,  A_EN, 32'h0F0, "R2 oe follows direction");
    chk(K_OUT, A_EN, 32'hFA5, "R2 out follows data");
    chk(K_RD,  A_DIR, 32'h0F0, "R12 upper bits read zero");
    // R3 input readback, two edges of latency
    pin_in = 12'hA5C;
    idle(1);
    chk(K_RD, A_IN, 32'hA5C, "R3 input readback");
    // R11 use-select
    wr(A_US, 32'hFFFF_FFFF);
    chk(K_RD, A_US, 32'hFFF, "R11 use-select readback");
    chk(K_OE, A_EN, 32'h0F0, "R11 use-select leaves pins alone");
    // R4 mode layout
    wr(A_MA, 32'hFFFF_FFFF);
    chk(K_RD, A_MA, 32'h7777_7777, "R4 mode A nibble width");
    wr(A_MB, 32'hFFFF_4321);
    chk(K_RD, A_MB, 32'h0000_4321, "R4 mode B only four pins");
    // detection setup: p0 rise, p1 fall, p2 both, p3 code 5, p4 high, rest 5
    pin_in = 12'h002;
    idle(4);
    wr(A_MA, 32'h5553_5401);
    wr(A_MB, 32'h0000_5555);
    wr(A_EN, 32'h0000_001F);
    chk(K_RD, A_ST, 32'h0, "R7 nothing latched yet");
    // R5 rising transitions
    pin_in = 12'h01F;
    idle(1);
    chk(K_RD, A_ST, 32'h0, "R5 not set on second edge");
    chk(K_RD, A_ST, 32'h015, "R5 R4 rise/both/high set, code 5 inert");
    chk(K_IRQ, A_EN, 32'h1, "R9 irq with unmasked status");
    // R6 R8 clear while high level holds: detection wins
    wr(A_CL, 32'h0000_0015);
    chk(K_RD, A_ST, 32'h010, "R6 level keeps status through clear");
    // falling transitions
    pin_in = 12'h000;
    idle(3);
    chk(K_RD, A_ST, 32'h016, "R5 fall/both set");
    wr(A_CL, 32'h0000_0010);
    chk(K_RD, A_ST, 32'h006, "R6 clear works once level gone");
    wr(A_CL, 32'h0000_0000);
    chk(K_RD, A_ST, 32'h006, "R8 zero clear has no effect");
    // R9 masking
    wr(A_MS, 32'h0000_0006);
    chk(K_RD,  A_MS, 32'h006, "R9 mask readback");
    chk(K_IRQ, A_EN, 32'h0, "R9 masked irq low");
    chk(K_RD,  A_PD, 32'h000, "R9 pending empty when masked");
    wr(A_MC, 32'h0000_0002);
    chk(K_RD,  A_MS, 32'h004, "R9 mask clear");
    chk(K_IRQ, A_EN, 32'h1, "R9 unmasked irq high");
    chk(K_RD,  A_PD, 32'h002, "R9 pending view");
    // R7 disable gating
    wr(A_EN, 32'h0);
    pin_in = 12'h001;
    idle(4);
    chk(K_RD, A_ST, 32'h006, "R7 disabled pin does not latch, old bits kept");
    wr(A_CL, 32'h0000_0006);
    chk(K_IRQ, A_EN, 32'h0, "R8 irq drops after clear");
    // R1 write-only and reserved words
    chk(K_RD, A_CL,  32'h0, "R1 clear reads zero");
    chk(K_RD, A_MC,  32'h0, "R1 mask clear reads zero");
    chk(K_RD, A_RSV, 32'h0, "R1 reserved reads zero");
    // R10 software reset
    wr(A_SR, 32'h1);
    chk(K_RD,  A_SR,  32'h1, "R10 reset bit reads back");
    chk(K_RD,  A_DIR, 32'h0, "R10 direction default");
    chk(K_OUT, A_EN,  32'h0, "R10 output default");
    chk(K_RD,  A_MA,  32'h0, "R10 mode default");
    chk(K_RD,  A_MS,  32'h0, "R10 mask default");
    chk(K_RD,  A_US,  32'h0, "R10 use-select default");
    wr(A_DIR, 32'h0000_0FFF);
    chk(K_RD, A_DIR, 32'h0, "R10 writes ignored while held");
    wr(A_SR, 32'h0);
    chk(K_RD, A_SR, 32'h0, "R10 release");
    wr(A_DIR, 32'h0000_000F);
    chk(K_OE, A_EN, 32'h00F, "R10 writes work after release");
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule